// File: doc/BRIEF.md
# Address-Channel Burst Splitter

This block turns one logical transfer request into a sequence of legal AXI4 address-channel bursts for a master port. A request gives a start byte address, a word count and a programmed upper bound on burst length. The splitter then emits bursts, each with an address and a length code, over a valid/ready handshake. Each burst stops at the first of four limits: the programmed bound, the protocol's 256-beat ceiling, the next 4 KB address boundary, or the words still left.

The bus width is a parameter of 4 to 64 bytes per beat, and must be a power of two. The width sets a ceiling of its own, because one burst may carry at most 4 KB. Only full-width, aligned word transfers are handled. The block does not move data, handle responses or track outstanding transactions. A new request is taken only while the block is idle. A one-cycle completion pulse follows the last burst.

Top module: `burst_splitter`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `burst_valid` is 0 and `done` is 0.
- R2: No burst exceeds the effective cap. The effective cap is the smaller of 256 beats and 4096 / `DATA_BYTES`, which is 256, 256, 256, 128 and 64 beats for 4, 8, 16, 32 and 64 bytes. A programmed bound of 0, or one above the cap, is replaced by the cap. Otherwise the programmed bound applies.
- R3: No burst crosses a 4 KB address boundary. When the address is within fewer than cap beats of the boundary, the burst ends exactly at that boundary.
- R4: Each burst after the first starts at the previous burst address plus beats × `DATA_BYTES`.
- R5: A request longer than the bound is issued as full-bound bursts followed by one remainder burst. For example, 100 words with a bound of 64 at address 0 gives lengths of 64 and then 36 beats.
- R6: A request shorter than the bound is issued as one burst of exactly its word count, with no padding.
- R7: While `burst_valid` is 1 and `burst_ready` is 0, `burst_valid`, `burst_addr` and `burst_len` hold their values.
- R8: A request is accepted only when `req_ready` is 1, which is only while idle. A `req_valid` raised during a busy period does not change the bursts being emitted.
- R9: `done` is 1 for exactly one cycle. That cycle directly follows the handshake of the last burst. In that cycle `req_ready` is 1 and `burst_valid` is 0.
- R10: A request with a word count of 0 emits no burst. `done` is 1 in the cycle after the request is accepted.
- R11: `burst_len` holds the beat count minus one, as 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address, aligned to `DATA_BYTES` |
| req_words | input | CNT_W | Number of full-width words to transfer |
| req_max_beats | input | 9 | Programmed burst bound in beats; 0 means the cap |
| burst_valid | output | 1 | Burst address and length valid |
| burst_ready | input | 1 | Address channel takes the burst |
| burst_addr | output | ADDR_W | Burst start byte address |
| burst_len | output | 8 | Beats in the burst minus one |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The properties assume that every start address is aligned to the bus width. Without that, the boundary and step checks would be measured against a misaligned base. They also assume that `DATA_BYTES` is a legal power of two. The directed stimulus uses only aligned addresses, including one placed 128 bytes below a 4 KB boundary. It drives `burst_ready` low on some cycles so that stalled bursts occur, and it raises a second request while the block is busy.

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int DATA_BYTES = 8,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_words,
  input  logic [8:0]        req_max_beats,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [7:0]        burst_len,
  output logic              done
);
  localparam int SH  = $clog2(DATA_BYTES);
  localparam int CAP = (4096 / DATA_BYTES > 256) ? 256 : 4096 / DATA_BYTES;
  localparam int MW  = (CNT_W > 13) ? CNT_W : 13;

  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  rem;
  logic [8:0]        lim;
  logic [12:0]       room;
  logic [MW-1:0]     lim_or_room, beats_x;
  logic [8:0]        beats;
  logic [8:0]        eff_max;
  logic              take, fire, last;

  assign eff_max     = (req_max_beats == 9'd0 || req_max_beats > 9'(CAP)) ? 9'(CAP) : req_max_beats;
  assign room        = 13'(4096 / DATA_BYTES) - 13'(cur_addr[11:SH]);
  assign lim_or_room = (MW'(room) < MW'(lim)) ? MW'(room) : MW'(lim);
  assign beats_x     = (MW'(rem) < lim_or_room) ? MW'(rem) : lim_or_room;
  assign beats       = beats_x[8:0];

  assign req_ready   = !busy;
  assign burst_valid = busy;
  assign burst_addr  = cur_addr;
  assign burst_len   = 8'(beats - 9'd1);

  assign take = req_valid && !busy;
  assign fire = busy && burst_ready;
  assign last = MW'(rem) == beats_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      rem      <= '0;
      lim      <= 9'(CAP);
      done     <= 1'b0;
    end else begin
      done <= (fire && last) || (take && req_words == '0);
      if (take) begin
        cur_addr <= req_addr;
        rem      <= req_words;
        lim      <= eff_max;
        busy     <= req_words != '0;
      end else if (fire) begin
        cur_addr <= cur_addr + (ADDR_W'(beats) << SH);
        rem      <= rem - CNT_W'(beats);
        busy     <= !last;
      end
    end
  end
endmodule

module burst_splitter_chk #(
  parameter int DATA_BYTES = 8,
  parameter int ADDR_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              burst_valid,
  input logic              burst_ready,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [7:0]        burst_len,
  input logic              done
);
  localparam int SH  = $clog2(DATA_BYTES);
  localparam int CAP = (4096 / DATA_BYTES > 256) ? 256 : 4096 / DATA_BYTES;

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> ({1'b0, burst_len} < 9'(CAP))); // R2
  AST_NO_4K_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (17'(burst_addr[11:0]) + ((17'(burst_len) + 17'd1) << SH)) <= 17'd4096); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && burst_ready ##1 burst_valid) |->
      burst_addr == $past(burst_addr) + ((ADDR_W'($past(burst_len)) + ADDR_W'(1)) << SH)); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_addr) && $stable(burst_len))); // R7
  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !burst_valid); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !burst_valid)); // R9
endmodule

bind burst_splitter burst_splitter_chk #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .burst_valid(burst_valid),
  .burst_ready(burst_ready), .burst_addr(burst_addr), .burst_len(burst_len), .done(done));

// File: tb/burst_splitter_test.sv
module burst_splitter_test;
  localparam int B   = 8;
  localparam int AW  = 32;
  localparam int CW  = 16;
  localparam int CAP = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_words = '0;
  logic [8:0]    req_max_beats = '0;
  logic          burst_valid;
  logic          burst_ready = 1'b0;
  logic [AW-1:0] burst_addr;
  logic [7:0]    burst_len;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_splitter #(.DATA_BYTES(B), .ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_words(req_words), .req_max_beats(req_max_beats),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_addr(burst_addr),
    .burst_len(burst_len), .done(done));

  task automatic check(input string rq, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Drives one request and walks its bursts; expected lengths come from the requirements.
  task automatic run(input string rq, input longint addr, input int words, input int maxb,
                     input bit stall, input bit intrude, input int exp_first);
    longint a = addr;
    int rem = words;
    int eff = (maxb == 0 || maxb > CAP) ? CAP : maxb;
    int k = 0;
    int first = -1;
    @(negedge clk);
    check({rq, " R8 ready when idle"}, req_ready, 1);
    req_valid = 1'b1; req_addr = AW'(addr); req_words = CW'(words); req_max_beats = 9'(maxb);
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin
      req_addr = 32'h0000_8000; req_words = 16'd3; req_max_beats = 9'd1;
    end else req_valid = 1'b0;
    if (words == 0) begin
      check({rq, " R10 done after zero count"}, done, 1);
      check({rq, " R10 no burst"}, burst_valid, 0);
      @(negedge clk);
      check({rq, " R9 done single cycle"}, done, 0);
      return;
    end
    while (rem > 0 && k < 2000) begin
      int room = int'((4096 - (a % 4096)) / B);
      int bt = rem;
      if (eff < bt) bt = eff;
      if (room < bt) bt = room;
      burst_ready = !(stall && (k % 3 == 0));
      check({rq, " R7/R8 valid while busy"}, burst_valid, 1);
      check({rq, " R4 address"}, burst_addr, a);
      check({rq, " R2/R3/R11 length"}, burst_len, bt - 1);
      check({rq, " R9 no early done"}, done, 0);
      if (intrude) check({rq, " R8 not ready while busy"}, req_ready, 0);
      if (first < 0) first = bt;
      if (burst_ready) begin
        a = a + longint'(bt) * B;
        rem = rem - bt;
      end
      k++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    burst_ready = 1'b0;
    check({rq, " R5/R6 first burst beats"}, first, exp_first);
    check({rq, " R9 done after last"}, done, 1);
    check({rq, " R9 idle at done"}, burst_valid, 0);
    check({rq, " R9 ready at done"}, req_ready, 1);
    @(negedge clk);
    check({rq, " R9 done single cycle"}, done, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 valid", burst_valid, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_split();   run("R5 100 by 64", 0, 100, 64, 0, 0, 64); endtask
  task automatic t_short();   run("R6 short", 32'h200, 10, 64, 0, 0, 10); endtask
  task automatic t_cross();   run("R3 boundary", 32'hF80, 40, 0, 0, 0, 16); endtask
  task automatic t_cap();     run("R2 cap zero", 32'h1000, 600, 0, 1, 0, 256); endtask
  task automatic t_clip();    run("R2 clipped", 32'h3000, 300, 300, 0, 0, 256); endtask
  task automatic t_zero();    run("R10 zero", 32'h40, 0, 8, 0, 0, 0); endtask
  task automatic t_intrude(); run("R8 intrude", 32'h5FC0, 50, 16, 1, 1, 8); endtask
  task automatic t_stall();   run("R7 stall", 32'h7000, 20, 4, 1, 0, 4); endtask

  initial begin
    #1;
    check("R1 done before reset release", done === 1'b1 ? 1 : 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_split();
    t_short();
    t_cross();
    t_cap();
    t_clip();
    t_zero();
    t_intrude();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule